// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds one byte that software reads to learn why the device last restarted. Three flag bits record the cause. Power-on, brown-out and parity-error events each arrive as a pulse. Each event changes the flags according to its own rule. Software re-arms the flags by writing through a simple register port that has an address, a write strobe and write data.

The top bit is not stored in the block. It repeats a configuration input that tells whether program-memory parity checking is enabled, and no reset event or write changes it. Bits 3 to 6 are not implemented.

The power-on pulse acts as an asynchronous reset and forces all three flags to known values. The brown-out and parity-error pulses are sampled on the rising clock edge. The block does not detect reset conditions and does not time resets.

Top module: `rst_cause_reg`

## Requirements
- R1: A write takes effect only when the write strobe is high and the address equals 8Eh. A write to any other address leaves the register value unchanged.
- R2: Bit 1, the power-on flag, reads 0 while the power-on pulse is high and afterwards. Brown-out and parity-error events do not change it.
- R3: Bit 2, the parity flag, reads 1 after a power-on pulse. It reads 0 from the clock edge after a parity-error event is sampled. A brown-out event does not change it.
- R4: Bit 0, the brown-out flag, reads 0 from the clock edge after a brown-out event is sampled. A parity-error event does not change it.
- R5: A write that is accepted loads write-data bits 0 to 2 into flag bits 0 to 2. The new value can be read after the clock edge that samples the write.
- R6: Bit 7 always equals the parity-enable configuration input. Writes and reset events never change it.
- R7: Bits 3 to 6 always read 0, whatever value is written to them.
- R8: If a brown-out or parity-error event is sampled on the same edge as a write, the whole write is discarded. The event rule is applied, and the other flags keep their values.
- R9: Bit 0 reads 0 after a power-on pulse, so the value is defined from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwron_evt_i | input | 1 | Power-on reset pulse, active high, asynchronous |
| brownout_evt_i | input | 1 | Brown-out reset pulse, active high, sampled on the clock |
| parerr_evt_i | input | 1 | Parity-error reset pulse, active high, sampled on the clock |
| cfg_par_en_i | input | 1 | Parity-enable setting from the configuration word |
| bus_addr_i | input | ADDR_W | Register port address |
| bus_we_i | input | 1 | Register port write strobe |
| bus_wdata_i | input | 8 | Register port write data |
| reg_o | output | 8 | Current register value |

## Verification
Writes, brown-out events and parity-error events are sampled on a rising edge. Their results can be read before the following edge, so each is due exactly one edge after the stimulus. The power-on pulse and the configuration mirror act combinationally. Their effect is therefore visible in the same cycle in which they change. The bench changes its inputs on the falling edge. A behavioural model is updated on each rising edge, and the model and the output are compared at the next falling edge, before any input changes. Each comparison therefore sees the result that is due at that point.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
   localparam int REG_W     = 8;
   localparam int N_FLAGS   = 3;
   localparam int BO_POS    = 0;
   localparam int PWR_POS   = 1;
   localparam int PAR_POS   = 2;
   localparam int MIRR_POS  = 7;
   // value each flag takes while the power-on pulse is high
   localparam logic [N_FLAGS-1:0] PWRON_VALS = 3'b100;
endpackage

// File: rtl/rcr_decode.sv
module rcr_decode #(
   parameter int          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h8E
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   output logic              hit_o
);
   always_comb hit_o = we_i && (addr_i == REG_ADDR);
endmodule

// File: rtl/rcr_flag.sv
module rcr_flag #(
   parameter logic PWRON_VAL = 1'b0,
   parameter bit   HAS_CLR   = 1'b1
) (
   input  logic clk,
   input  logic pwron_i,
   input  logic clr_i,
   input  logic wr_i,
   input  logic d_i,
   output logic q_o
);
   logic clr_eff;

   generate
      if (HAS_CLR) begin : g_clr
         always_comb clr_eff = clr_i;
      end else begin : g_noclr
         always_comb clr_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or posedge pwron_i) begin
      if (pwron_i)      q_o <= PWRON_VAL;
      else if (clr_eff) q_o <= 1'b0;
      else if (wr_i)    q_o <= d_i;
   end

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (pwron_i)
      (!clr_i && !wr_i) |=> $stable(q_o)); // R2
   AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (pwron_i)
      (wr_i && !clr_i) |=> (q_o == $past(d_i))); // R5
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rcr_pkg::*;
#(
   parameter int              ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h8E
) (
   input  logic              clk,
   input  logic              pwron_evt_i,
   input  logic              brownout_evt_i,
   input  logic              parerr_evt_i,
   input  logic              cfg_par_en_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [REG_W-1:0]  bus_wdata_i,
   output logic [REG_W-1:0]  reg_o
);
   localparam int UNUSED_W = MIRR_POS - N_FLAGS;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("rst_cause_reg: ADDR_W must be at least 1");
      end
      if (UNUSED_W < 0) begin : g_bad_layout
         $error("rst_cause_reg: flag bits overlap the mirror bit");
      end
   endgenerate

   logic               hit;
   logic               any_evt;
   logic               wr_ok;
   logic [N_FLAGS-1:0] clr_vec;
   logic [N_FLAGS-1:0] flags;

   rcr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
      .addr_i (bus_addr_i),
      .we_i   (bus_we_i),
      .hit_o  (hit)
   );

   always_comb begin
      any_evt           = brownout_evt_i | parerr_evt_i;
      wr_ok             = hit & ~any_evt;
      clr_vec           = '0;
      clr_vec[BO_POS]   = brownout_evt_i;
      clr_vec[PAR_POS]  = parerr_evt_i;
   end

   generate
      for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
         rcr_flag #(
            .PWRON_VAL (PWRON_VALS[i]),
            .HAS_CLR   (i != PWR_POS)
         ) u_flag (
            .clk     (clk),
            .pwron_i (pwron_evt_i),
            .clr_i   (clr_vec[i]),
            .wr_i    (wr_ok),
            .d_i     (bus_wdata_i[i]),
            .q_o     (flags[i])
         );
      end
   endgenerate

   always_comb begin
      reg_o                   = '0;
      reg_o[N_FLAGS-1:0]      = flags;
      reg_o[MIRR_POS]         = cfg_par_en_i;
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (pwron_evt_i)
      (bus_we_i && bus_addr_i == REG_ADDR && !brownout_evt_i && !parerr_evt_i)
      |=> (reg_o[2:0] == $past(bus_wdata_i[2:0]))); // R5
   AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (pwron_evt_i)
      (!(bus_we_i && bus_addr_i == REG_ADDR) && !brownout_evt_i && !parerr_evt_i)
      |=> $stable(reg_o[2:0])); // R1
   AST_BO_CLEARS: assert property (@(posedge clk) disable iff (pwron_evt_i)
      brownout_evt_i |=> (reg_o[0] == 1'b0)); // R4
   AST_PAR_CLEARS: assert property (@(posedge clk) disable iff (pwron_evt_i)
      parerr_evt_i |=> (reg_o[2] == 1'b0)); // R3
   AST_PWR_KEEPS: assert property (@(posedge clk) disable iff (pwron_evt_i)
      (brownout_evt_i || parerr_evt_i) |=> $stable(reg_o[1])); // R8
endmodule

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
   logic       clk = 1'b0;
   logic       pwron = 1'b1;
   logic       bo = 1'b0;
   logic       pe = 1'b0;
   logic       cfg = 1'b1;
   logic [7:0] addr = 8'h00;
   logic       we = 1'b0;
   logic [7:0] wd = 8'h00;
   logic [7:0] dout;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string cur_req = "R9";

   // model state
   bit m_bo = 0, m_pwr = 0, m_par = 1;

   always #2 clk = ~clk; // 250 MHz

   rst_cause_reg dut_i (
      .clk(clk), .pwron_evt_i(pwron), .brownout_evt_i(bo), .parerr_evt_i(pe),
      .cfg_par_en_i(cfg), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wd),
      .reg_o(dout)
   );

   always @(posedge clk) begin
      if (pwron) begin
         m_bo = 0; m_pwr = 0; m_par = 1;
      end else begin
         if (pe) m_par = 0;
         if (bo) m_bo = 0;
         if (we && addr == 8'h8E && !bo && !pe) begin
            m_bo = wd[0]; m_pwr = wd[1]; m_par = wd[2];
         end
      end
   end

   task automatic check(string req);
      logic [7:0] exp;
      exp = {cfg, 4'b0000, m_par, m_pwr, m_bo};
      total++;
      if (dout !== exp) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h at %0t", req, dout, exp, $time);
      end
   endtask

   // one cycle: check result of previous stimulus, then drive new stimulus
   task automatic step(input logic p, input logic b, input logic e,
                       input logic w, input logic [7:0] a, input logic [7:0] d,
                       input logic c, input string req);
      @(negedge clk);
      check(cur_req);
      pwron = p; bo = b; pe = e; we = w; addr = a; wd = d; cfg = c;
      cur_req = req;
   endtask

   initial begin
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'h8E, 8'h00, 1, "R9");
      step(0, 0, 0, 0, 8'h00, 8'h00, 1, "R2");           // reset state R2 R3 R9
      step(0, 0, 0, 1, 8'h8E, 8'h07, 1, "R5");           // set all flags
      step(0, 0, 0, 0, 8'h00, 8'h00, 1, "R5");
      step(0, 0, 0, 1, 8'h8E, 8'hF8, 0, "R7");           // R6 R7: upper bits ignored
      step(0, 0, 0, 0, 8'h00, 8'h00, 0, "R6");
      step(0, 0, 0, 1, 8'h85, 8'h07, 1, "R1");           // wrong address
      step(0, 0, 0, 1, 8'h8E, 8'h05, 1, "R1");           // strobe test next
      step(0, 0, 0, 0, 8'h8E, 8'h02, 1, "R1");           // no strobe
      step(0, 0, 0, 1, 8'h8E, 8'h07, 1, "R5");
      step(0, 1, 0, 0, 8'h00, 8'h00, 1, "R4");           // brown-out
      step(0, 0, 0, 1, 8'h8E, 8'h07, 1, "R5");
      step(0, 0, 1, 0, 8'h00, 8'h00, 1, "R3");           // parity error
      step(0, 0, 0, 1, 8'h8E, 8'h07, 1, "R5");
      step(0, 1, 0, 1, 8'h8E, 8'h00, 1, "R8");           // brown-out with write
      step(0, 0, 0, 1, 8'h8E, 8'h07, 1, "R5");
      step(0, 0, 1, 1, 8'h8E, 8'h02, 1, "R8");           // parity with write
      step(0, 0, 0, 0, 8'h00, 8'h00, 0, "R6");
      step(0, 0, 0, 1, 8'h8E, 8'h07, 1, "R5");
      step(1, 0, 0, 0, 8'h00, 8'h00, 1, "R2");           // power-on mid-run
      step(0, 0, 0, 0, 8'h00, 8'h00, 1, "R3");
      for (int i = 0; i < 400; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         step((r[7:5] == 3'b000) && r[0], r[1] & r[2], r[3] & r[4],
              r[5], r[6] ? 8'h8E : 8'($urandom), 8'($urandom), r[7], "R5");
      end
      step(0, 0, 0, 0, 8'h00, 8'h00, 1, "R5");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule